// File: doc/BRIEF.md
# Unaligned Sector Transfer Aligner

This block sits between a byte-addressed DMA engine and a storage device that only moves whole 512-byte sectors. It takes a request of a byte offset, a byte length and a direction, and produces a sector-granular command: the first sector and the number of sectors. It also produces an ordered list of up to three segment descriptors that tell a downstream data mover how to split the sector stream. The list is a leading pad, the caller's payload and a trailing pad.

On a read, each pad describes bytes of the edge sectors that the mover throws away. On a write, a partial first or last sector has to be written back whole. Before the command is issued, the block fetches each partial edge sector from storage into one of two internal sector banks. The pads then point into those banks, so the old bytes around the payload are written back unchanged. The mover reads the banks through a byte read port.

The controller has eight states. IDLE accepts a request and goes to PLAN. PLAN registers the computed command and segment list. From PLAN it goes to HEAD_REQ on a write whose start is unaligned, otherwise to TAIL_REQ on a write whose end is unaligned, otherwise to CMD. HEAD_REQ issues the leading pre-read and, once accepted, goes to HEAD_FILL. HEAD_FILL stores one byte per valid beat. After the last byte it goes to TAIL_REQ when the tail also needs a pre-read, otherwise to CMD. TAIL_REQ goes to TAIL_FILL, and TAIL_FILL goes to CMD when full. CMD holds the sector command until it is accepted, then goes to EMIT. EMIT presents the segments one at a time and returns to IDLE after the last one is accepted.

Top module: `sector_aligner`

## Requirements
- R1: `req_ready` is high only when the block is idle. From the cycle after a request is accepted until the last segment is accepted, `busy` is high and `req_ready` is low, and a request offered during that time has no effect on the transaction in progress.
- R2: The command carries start sector = offset >> 9 and count = ceil(((offset mod 512) + length) / 512). `blk_write` equals the request direction.
- R3: When offset mod 512 is nonzero, a leading segment of (offset mod 512) bytes comes first. Its `seg_start` is 0.
- R4: When (offset + length) mod 512 = t is nonzero, a trailing segment of 512 − t bytes comes last. Its `seg_start` is t.
- R5: On a read, the pads use source code 1 (discard) and no pre-read is issued. `seg_src` encodes 0 = caller memory, 1 = discard, 2 = head bank, 3 = tail bank.
- R6: On a write with an unaligned start, sector offset >> 9 is pre-read into the head bank (bank 0). The leading segment has source 2, so the bank's bytes 0 to head−1 precede the payload.
- R7: On a write with an unaligned end, sector (offset + length) >> 9 is pre-read into the tail bank (bank 1). The trailing segment has source 3, so the bank's bytes t to 511 follow the payload.
- R8: Exactly one payload segment (source 0, `seg_bytes` = length, `seg_start` = 0) is emitted, whichever edges are unaligned.
- R9: A request whose start and end are both sector-aligned yields a single payload segment and no pre-read.
- R10: All pre-reads finish (512 bytes each) before `blk_valid` rises. No segment is offered before the command is accepted, and a pre-read request never coincides with a command or a segment.
- R11: While `blk_valid` or `seg_valid` waits for its ready, it stays high and the attached fields stay stable.
- R12: `seg_last` is high exactly on the final segment of the list.
- R13: The head-bank and tail-bank bytes read back through the buffer port equal the bytes the storage returned for the corresponding pre-read sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write to storage, 0 = read |
| req_offset | input | OFF_W | Byte offset of the transfer |
| req_len | input | LEN_W | Byte length of the transfer (nonzero) |
| busy | output | 1 | Transaction in progress |
| pr_req_valid | output | 1 | Edge-sector pre-read request |
| pr_req_ready | input | 1 | Storage accepts the pre-read |
| pr_sector | output | OFF_W−9 | Sector to pre-read |
| pr_data_valid | input | 1 | Pre-read byte valid |
| pr_data | input | 8 | Pre-read byte, in sector order |
| blk_valid | output | 1 | Sector command valid |
| blk_ready | input | 1 | Command accepted |
| blk_write | output | 1 | Command direction |
| blk_sector | output | OFF_W−9 | First sector |
| blk_count | output | LEN_W−7 | Sector count |
| seg_valid | output | 1 | Segment descriptor valid |
| seg_ready | input | 1 | Segment accepted |
| seg_src | output | 2 | Segment source code |
| seg_start | output | 9 | Byte index inside the edge sector |
| seg_bytes | output | LEN_W | Segment length in bytes |
| seg_last | output | 1 | Final segment of the list |
| buf_rd_bank | input | 1 | Bank select for the buffer read port |
| buf_rd_addr | input | 9 | Byte index for the buffer read port |
| buf_rd_data | output | 8 | Byte read from the selected bank |

## Verification
The hardest case to reach is a write whose start and end fall inside the same sector. That sector must then be fetched twice, into both banks, and the two pads must cover complementary ranges of it. Directed requests such as offset 100, length 50 create this case. Random offsets and lengths over a few sectors mix in the other head and tail combinations, under random back-pressure on the command and the segments and random gaps in the pre-read data. During each transaction a conflicting request is held on the input to show it is ignored.

// File: rtl/sta_pkg.sv
package sta_pkg;

    typedef enum logic [1:0] {
        SRC_MEM      = 2'd0,
        SRC_DISCARD  = 2'd1,
        SRC_HEAD_BUF = 2'd2,
        SRC_TAIL_BUF = 2'd3
    } seg_src_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAN,
        ST_HEAD_REQ,
        ST_HEAD_FILL,
        ST_TAIL_REQ,
        ST_TAIL_FILL,
        ST_CMD,
        ST_EMIT
    } state_t;

endpackage

// File: rtl/sta_planner.sv
module sta_planner #(
    parameter int OFF_W        = 32,
    parameter int LEN_W        = 16,
    parameter int SECTOR_BYTES = 512,
    localparam int SB_W  = $clog2(SECTOR_BYTES),
    localparam int SEC_W = OFF_W - SB_W,
    localparam int CNT_W = LEN_W - SB_W + 2
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [LEN_W-1:0] len,
    output logic [SEC_W-1:0] start_sec,
    output logic [SEC_W-1:0] end_sec,
    output logic [CNT_W-1:0] sec_count,
    output logic [SB_W-1:0]  head_bytes,
    output logic [SB_W-1:0]  tail_bytes,
    output logic             head_unal,
    output logic             tail_unal
);

    logic [OFF_W:0]   end_addr;
    logic [LEN_W+1:0] span;
    logic [LEN_W+1:0] rounded;

    always_comb begin
        end_addr   = {1'b0, offset} + (OFF_W+1)'(len);
        head_bytes = offset[SB_W-1:0];
        tail_bytes = end_addr[SB_W-1:0];
        head_unal  = (head_bytes != '0);
        tail_unal  = (tail_bytes != '0);
        start_sec  = offset[OFF_W-1:SB_W];
        end_sec    = end_addr[OFF_W-1:SB_W];
        span       = (LEN_W+2)'(head_bytes) + (LEN_W+2)'(len);
        rounded    = span + (LEN_W+2)'(SECTOR_BYTES - 1);
        sec_count  = rounded[LEN_W+1:SB_W];
    end

endmodule

// File: rtl/sta_seg_list.sv
module sta_seg_list
    import sta_pkg::*;
#(
    parameter int LEN_W        = 16,
    parameter int SECTOR_BYTES = 512,
    localparam int SB_W = $clog2(SECTOR_BYTES)
) (
    input  logic                       is_write,
    input  logic                       head_unal,
    input  logic                       tail_unal,
    input  logic [SB_W-1:0]            head_bytes,
    input  logic [SB_W-1:0]            tail_bytes,
    input  logic [LEN_W-1:0]           len,
    output logic [2:0][1:0]            src,
    output logic [2:0][SB_W-1:0]       start,
    output logic [2:0][LEN_W-1:0]      nbytes,
    output logic [1:0]                 n
);

    logic [1:0] k;

    always_comb begin
        src    = '0;
        start  = '0;
        nbytes = '0;
        k      = 2'd0;
        if (head_unal) begin
            src[0]    = is_write ? SRC_HEAD_BUF : SRC_DISCARD;
            start[0]  = '0;
            nbytes[0] = LEN_W'(head_bytes);
            k         = 2'd1;
        end
        src[k]    = SRC_MEM;
        start[k]  = '0;
        nbytes[k] = len;
        k         = k + 2'd1;
        if (tail_unal) begin
            src[k]    = is_write ? SRC_TAIL_BUF : SRC_DISCARD;
            start[k]  = tail_bytes;
            nbytes[k] = LEN_W'(SECTOR_BYTES) - LEN_W'(tail_bytes);
            k         = k + 2'd1;
        end
        n = k;
    end

endmodule

// File: rtl/sta_edge_buf.sv
module sta_edge_buf #(
    parameter int SECTOR_BYTES = 512,
    parameter int BANKS        = 2,
    localparam int SB_W = $clog2(SECTOR_BYTES),
    localparam int BK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [BK_W-1:0] wr_bank,
    input  logic [SB_W-1:0] wr_addr,
    input  logic [7:0]      wr_data,
    input  logic [BK_W-1:0] rd_bank,
    input  logic [SB_W-1:0] rd_addr,
    output logic [7:0]      rd_data
);

    logic [7:0] rd_word [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [7:0] mem [SECTOR_BYTES];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == BK_W'(b))) begin
                mem[wr_addr] <= wr_data;
            end
        end

        assign rd_word[b] = mem[rd_addr];
    end

    assign rd_data = rd_word[rd_bank];

endmodule

// File: rtl/sector_aligner.sv
module sector_aligner
    import sta_pkg::*;
#(
    parameter int OFF_W        = 32,
    parameter int LEN_W        = 16,
    parameter int SECTOR_BYTES = 512
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    req_valid,
    output logic                                    req_ready,
    input  logic                                    req_write,
    input  logic [OFF_W-1:0]                        req_offset,
    input  logic [LEN_W-1:0]                        req_len,
    output logic                                    busy,
    output logic                                    pr_req_valid,
    input  logic                                    pr_req_ready,
    output logic [OFF_W-$clog2(SECTOR_BYTES)-1:0]   pr_sector,
    input  logic                                    pr_data_valid,
    input  logic [7:0]                              pr_data,
    output logic                                    blk_valid,
    input  logic                                    blk_ready,
    output logic                                    blk_write,
    output logic [OFF_W-$clog2(SECTOR_BYTES)-1:0]   blk_sector,
    output logic [LEN_W-$clog2(SECTOR_BYTES)+1:0]   blk_count,
    output logic                                    seg_valid,
    input  logic                                    seg_ready,
    output logic [1:0]                              seg_src,
    output logic [$clog2(SECTOR_BYTES)-1:0]         seg_start,
    output logic [LEN_W-1:0]                        seg_bytes,
    output logic                                    seg_last,
    input  logic                                    buf_rd_bank,
    input  logic [$clog2(SECTOR_BYTES)-1:0]         buf_rd_addr,
    output logic [7:0]                              buf_rd_data
);

    localparam int SB_W  = $clog2(SECTOR_BYTES);
    localparam int SEC_W = OFF_W - SB_W;
    localparam int CNT_W = LEN_W - SB_W + 2;
    localparam logic [SB_W-1:0] FILL_LAST = SB_W'(SECTOR_BYTES - 1);

    state_t state, nxt;

    // captured request
    logic              wr_q;
    logic [OFF_W-1:0]  off_q;
    logic [LEN_W-1:0]  len_q;

    // planner outputs
    logic [SEC_W-1:0]  p_start, p_end;
    logic [CNT_W-1:0]  p_count;
    logic [SB_W-1:0]   p_head, p_tail;
    logic              p_head_unal, p_tail_unal;

    // segment builder outputs
    logic [2:0][1:0]        l_src;
    logic [2:0][SB_W-1:0]   l_start;
    logic [2:0][LEN_W-1:0]  l_bytes;
    logic [1:0]             l_n;

    // registered plan
    logic [SEC_W-1:0]       start_q, end_q;
    logic [CNT_W-1:0]       count_q;
    logic                   head_pre_q, tail_pre_q;
    logic [2:0][1:0]        src_q;
    logic [2:0][SB_W-1:0]   segstart_q;
    logic [2:0][LEN_W-1:0]  segbytes_q;
    logic [1:0]             n_q;

    logic [SB_W-1:0]   fill_cnt;
    logic [1:0]        emit_idx;
    logic              buf_wr_en;
    logic              buf_wr_bank;

    sta_planner #(
        .OFF_W(OFF_W), .LEN_W(LEN_W), .SECTOR_BYTES(SECTOR_BYTES)
    ) u_plan (
        .offset    (off_q),
        .len       (len_q),
        .start_sec (p_start),
        .end_sec   (p_end),
        .sec_count (p_count),
        .head_bytes(p_head),
        .tail_bytes(p_tail),
        .head_unal (p_head_unal),
        .tail_unal (p_tail_unal)
    );

    sta_seg_list #(
        .LEN_W(LEN_W), .SECTOR_BYTES(SECTOR_BYTES)
    ) u_list (
        .is_write  (wr_q),
        .head_unal (p_head_unal),
        .tail_unal (p_tail_unal),
        .head_bytes(p_head),
        .tail_bytes(p_tail),
        .len       (len_q),
        .src       (l_src),
        .start     (l_start),
        .nbytes    (l_bytes),
        .n         (l_n)
    );

    sta_edge_buf #(
        .SECTOR_BYTES(SECTOR_BYTES), .BANKS(2)
    ) u_buf (
        .clk    (clk),
        .wr_en  (buf_wr_en),
        .wr_bank(buf_wr_bank),
        .wr_addr(fill_cnt),
        .wr_data(pr_data),
        .rd_bank(buf_rd_bank),
        .rd_addr(buf_rd_addr),
        .rd_data(buf_rd_data)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (req_valid) nxt = ST_PLAN;
            ST_PLAN: begin
                if (wr_q && p_head_unal)      nxt = ST_HEAD_REQ;
                else if (wr_q && p_tail_unal) nxt = ST_TAIL_REQ;
                else                          nxt = ST_CMD;
            end
            ST_HEAD_REQ:  if (pr_req_ready) nxt = ST_HEAD_FILL;
            ST_HEAD_FILL: if (pr_data_valid && fill_cnt == FILL_LAST)
                              nxt = tail_pre_q ? ST_TAIL_REQ : ST_CMD;
            ST_TAIL_REQ:  if (pr_req_ready) nxt = ST_TAIL_FILL;
            ST_TAIL_FILL: if (pr_data_valid && fill_cnt == FILL_LAST) nxt = ST_CMD;
            ST_CMD:       if (blk_ready) nxt = ST_EMIT;
            ST_EMIT:      if (seg_ready && seg_last) nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready    = (state == ST_IDLE);
        busy         = (state != ST_IDLE);
        pr_req_valid = (state == ST_HEAD_REQ) || (state == ST_TAIL_REQ);
        pr_sector    = (state == ST_TAIL_REQ) ? end_q : start_q;
        buf_wr_en    = pr_data_valid &&
                       ((state == ST_HEAD_FILL) || (state == ST_TAIL_FILL));
        buf_wr_bank  = (state == ST_TAIL_FILL);
        blk_valid    = (state == ST_CMD);
        blk_write    = wr_q;
        blk_sector   = start_q;
        blk_count    = count_q;
        seg_valid    = (state == ST_EMIT);
        seg_src      = src_q[emit_idx];
        seg_start    = segstart_q[emit_idx];
        seg_bytes    = segbytes_q[emit_idx];
        seg_last     = (emit_idx == (n_q - 2'd1));
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q       <= 1'b0;
            off_q      <= '0;
            len_q      <= '0;
            start_q    <= '0;
            end_q      <= '0;
            count_q    <= '0;
            head_pre_q <= 1'b0;
            tail_pre_q <= 1'b0;
            src_q      <= '0;
            segstart_q <= '0;
            segbytes_q <= '0;
            n_q        <= 2'd1;
            fill_cnt   <= '0;
            emit_idx   <= '0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                wr_q  <= req_write;
                off_q <= req_offset;
                len_q <= req_len;
            end
            if (state == ST_PLAN) begin
                start_q    <= p_start;
                end_q      <= p_end;
                count_q    <= p_count;
                head_pre_q <= wr_q && p_head_unal;
                tail_pre_q <= wr_q && p_tail_unal;
                src_q      <= l_src;
                segstart_q <= l_start;
                segbytes_q <= l_bytes;
                n_q        <= l_n;
            end
            if (state == ST_HEAD_REQ || state == ST_TAIL_REQ) fill_cnt <= '0;
            else if (buf_wr_en)                              fill_cnt <= fill_cnt + 1'b1;
            if (state == ST_CMD)                   emit_idx <= '0;
            else if (state == ST_EMIT && seg_ready) emit_idx <= emit_idx + 2'd1;
        end
    end

    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy && !req_ready));

    // R10
    preread_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pr_req_valid |-> (!blk_valid && !seg_valid));

    // R11
    blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && !blk_ready) |=> (blk_valid && $stable(blk_sector) && $stable(blk_count)));

    // R11
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_src) && $stable(seg_bytes)
                                       && $stable(seg_start)));

    // R4
    pad_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && seg_src != 2'd0) |->
        (seg_bytes != '0 &&
         ((LEN_W+1)'(seg_start) + (LEN_W+1)'(seg_bytes)) <= (LEN_W+1)'(SECTOR_BYTES)));

    // R5
    read_no_preread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_q) |-> !pr_req_valid);

endmodule

// File: tb/sector_aligner_test.sv
`timescale 1ns/1ps
module sector_aligner_test;

    localparam int SECT = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_offset = '0;
    logic [15:0] req_len = '0;
    logic        busy;
    logic        pr_req_valid;
    logic        pr_req_ready = 1'b1;
    logic [22:0] pr_sector;
    logic        pr_data_valid = 1'b0;
    logic [7:0]  pr_data = '0;
    logic        blk_valid;
    logic        blk_ready = 1'b0;
    logic        blk_write;
    logic [22:0] blk_sector;
    logic [8:0]  blk_count;
    logic        seg_valid;
    logic        seg_ready = 1'b0;
    logic [1:0]  seg_src;
    logic [8:0]  seg_start;
    logic [15:0] seg_bytes;
    logic        seg_last;
    logic        buf_rd_bank = 1'b0;
    logic [8:0]  buf_rd_addr = '0;
    logic [7:0]  buf_rd_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sector_aligner uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_offset(req_offset), .req_len(req_len), .busy(busy),
        .pr_req_valid(pr_req_valid), .pr_req_ready(pr_req_ready), .pr_sector(pr_sector),
        .pr_data_valid(pr_data_valid), .pr_data(pr_data),
        .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_write(blk_write),
        .blk_sector(blk_sector), .blk_count(blk_count),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_src(seg_src),
        .seg_start(seg_start), .seg_bytes(seg_bytes), .seg_last(seg_last),
        .buf_rd_bank(buf_rd_bank), .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data)
    );

    function automatic logic [7:0] pat(int sec, int i);
        return 8'((sec * 13 + i * 7) ^ 8'h3C);
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_txn(bit wr, int off, int len);
        int head, endb, tail, cnt, en, npre, pre_sec [2], nseg, cyc;
        int e_src [3], e_st [3], e_by [3];
        int got_pre, got_pre_sec [2], seg_k, strm_sec, idx;
        bit streaming, done, blk_seen, hold_ok;
        head = off % SECT;
        endb = off + len;
        tail = endb % SECT;
        cnt  = (head + len + SECT - 1) / SECT;
        npre = 0;
        if (wr && head != 0) begin pre_sec[npre] = off / SECT; npre++; end
        if (wr && tail != 0) begin pre_sec[npre] = endb / SECT; npre++; end
        en = 0;
        if (head != 0) begin e_src[en] = wr ? 2 : 1; e_st[en] = 0; e_by[en] = head; en++; end
        e_src[en] = 0; e_st[en] = 0; e_by[en] = len; en++;
        if (tail != 0) begin e_src[en] = wr ? 3 : 1; e_st[en] = tail; e_by[en] = SECT - tail; en++; end

        @(negedge clk);
        req_valid = 1; req_write = wr; req_offset = 32'(off); req_len = 16'(len);
        @(negedge clk);
        // conflicting request held during the transaction (R1)
        req_write = ~wr; req_offset = 32'(off + 1234); req_len = 16'(len + 77);
        got_pre = 0; seg_k = 0; streaming = 0; done = 0; blk_seen = 0; hold_ok = 1; idx = 0;
        strm_sec = 0;
        for (cyc = 0; cyc < 6000 && !done; cyc++) begin
            if (!busy || req_ready) hold_ok = 0;
            // storage model
            if (streaming) begin
                if (idx == SECT) begin
                    streaming = 0; pr_data_valid = 0;
                end else if (($urandom % 8) == 0) begin
                    pr_data_valid = 0;
                end else begin
                    pr_data_valid = 1; pr_data = pat(strm_sec, idx); idx++;
                end
            end
            if (pr_req_valid && !streaming) begin
                if (got_pre < 2) got_pre_sec[got_pre] = int'(pr_sector);
                got_pre++;
                strm_sec = int'(pr_sector); streaming = 1; idx = 0; pr_data_valid = 0;
            end
            // command sink
            blk_ready = ($urandom % 4) != 0;
            if (blk_valid && blk_ready) begin
                blk_seen = 1;
                // R2
                check(blk_sector == 23'(off / SECT), "R2", "blk_sector", blk_sector, off / SECT);
                check(blk_count == 9'(cnt), "R2", "blk_count", blk_count, cnt);
                check(blk_write == wr, "R2", "blk_write", blk_write, wr);
                // R10
                check(got_pre == npre && !streaming, "R10", "prereads done before command",
                      got_pre, npre);
            end
            // segment sink
            seg_ready = ($urandom % 3) != 0;
            if (seg_valid && seg_ready) begin
                check(blk_seen, "R10", "segment after command", blk_seen, 1);
                if (seg_k < en) begin
                    // R3 R4 R5 R6 R7 R8
                    check(int'(seg_src) == e_src[seg_k], "R8", "seg_src", seg_src, e_src[seg_k]);
                    check(int'(seg_start) == e_st[seg_k], "R4", "seg_start", seg_start, e_st[seg_k]);
                    check(int'(seg_bytes) == e_by[seg_k], "R3", "seg_bytes", seg_bytes, e_by[seg_k]);
                end
                // R12
                check(seg_last == (seg_k == en - 1), "R12", "seg_last", seg_last, seg_k == en - 1);
                if (seg_src >= 2) begin
                    int bsec, a0, a1;
                    bsec = (seg_src == 2) ? off / SECT : endb / SECT;
                    a0 = int'(seg_start);
                    a1 = int'(seg_start) + int'(seg_bytes) - 1;
                    buf_rd_bank = (seg_src == 3);
                    buf_rd_addr = 9'(a0);
                    #0.3;
                    // R13
                    check(buf_rd_data == pat(bsec, a0), "R13", "bank first byte", buf_rd_data, pat(bsec, a0));
                    buf_rd_addr = 9'(a1);
                    #0.3;
                    check(buf_rd_data == pat(bsec, a1), "R13", "bank last byte", buf_rd_data, pat(bsec, a1));
                end
                seg_k++;
                if (seg_last) begin done = 1; req_valid = 0; end
            end
            @(negedge clk);
        end
        blk_ready = 0; seg_ready = 0; pr_data_valid = 0; req_valid = 0;
        check(done, "R1", "transaction completes", done, 1);
        check(seg_k == en, "R8", "segment count", seg_k, en);
        // R6 R7 R5 R9: pre-read count and sectors
        check(got_pre == npre, "R9", "pre-read count", got_pre, npre);
        for (int i = 0; i < npre && i < got_pre; i++)
            check(got_pre_sec[i] == pre_sec[i], (i == 0 && head != 0) ? "R6" : "R7",
                  "pre-read sector", got_pre_sec[i], pre_sec[i]);
        check(hold_ok, "R1", "busy high and req_ready low while active", hold_ok, 1);
        check(req_ready && !busy, "R1", "idle after last segment", req_ready, 1);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(req_ready && !busy && !blk_valid && !seg_valid && !pr_req_valid,
              "R1", "reset state", {req_ready, busy, blk_valid, seg_valid, pr_req_valid}, 5'b10000);
        rst_n = 1;
        // directed corners
        run_txn(0, 1024, 2048);   // R9 aligned read
        run_txn(1, 512, 512);     // R9 aligned write, no pre-read
        run_txn(0, 100, 900);     // R5 read both pads
        run_txn(1, 100, 1000);    // R6 R7 write both edges
        run_txn(1, 100, 50);      // same sector both edges
        run_txn(1, 1536, 100);    // tail only
        run_txn(1, 700, 836);     // head only, end aligned
        run_txn(0, 511, 1);       // single byte at sector end
        run_txn(1, 0, 1);         // single byte at sector start
        run_txn(0, 3, 509);       // head only read
        // random mix
        for (int t = 0; t < 30; t++) begin
            int o, l;
            o = int'($urandom % 8192);
            l = 1 + int'($urandom % 3000);
            if (($urandom % 5) == 0) o = o & ~(SECT - 1);
            run_txn(bit'($urandom % 2), o, l);
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule